// File: doc/BRIEF.md
# Open-Drain Output Port with Pull-Up Control

This block is a four-pin open-drain output port on a byte-wide register bus. A data latch chooses, pin by pin, whether the pin is pulled low by its low-side driver (latch bit 0) or released (latch bit 1). A released pin floats, or goes high if its pull-up is on. A second register turns each pin's pull-up on or off. To use a pin as an analog input, software writes 1 to its latch bit so that the driver stays off.

Reading the data register returns the latch contents and never the pin level. The outputs also depend on the chip state. During reset, every driver and every pull-up is released. In stop mode with the hold flag clear, all pins float. In stop mode with the hold flag set, each pin whose pull-up is selected is held high by its pull-up.

Top module: `odport_top`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), the data latch holds 0xF and the pull-up register holds 0x0. A read at 0x0F returns 0x0F and a read at 0x10 returns 0x00.
- R2: In run mode (stopMode low, rstN high), a write at 0x0F makes drvLowEn equal to the inverse of busWdata[3:0] from the next cycle on. A 0 bit drives its pin low.
- R3: In run mode, a latch bit of 1 turns its driver off (drvLowEn bit 0).
- R4: A read at address 0x0F returns the latch in bits [3:0] and 0 in bits [7:4]. Writes to bits [7:4] have no effect.
- R5: The pull-up register sits at address 0x10. Bit i controls pin i. It is written from busWdata[3:0] and reads back in bits [3:0], with bits [7:4] reading 0.
- R6: A write takes effect at the rising clock edge on which busWe is sampled high. Read data follows busAddr and busRe without a clock. When busRe is low or the address is unmapped, busRdata is 0. Writes to unmapped addresses change no register.
- R7: In stop mode with holdPins high, pullUpEn equals the pull-up register. drvLowEn equals the inverted latch masked by the inverted pull-up register, so a pin with a pull-up is never driven low.
- R8: In stop mode with holdPins low, drvLowEn and pullUpEn are all 0, and the register contents are kept.
- R9: While rstN is low, pullUpEn and drvLowEn are all 0, even before the reset edge and whatever the pull-up register holds.
- R10: In run mode, pullUpEn is the pull-up register ANDed with the latch, so a pull-up is only active on a released pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; also releases the pads at once |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busRdata | output | 8 | Combinational read data |
| stopMode | input | 1 | Low-power stop mode active |
| holdPins | input | 1 | Keep pin levels in stop mode |
| drvLowEn | output | 4 | Per-pin enable of the low-side driver |
| pullUpEn | output | 4 | Per-pin pull-up enable |

## Verification
The assertions check on every cycle that the pads are released during reset and in stop mode without hold. They also check that a driver and a pull-up are never on together on one pin, that idle reads and the upper read bits are zero, and that a data write appears on the drivers one cycle later. Reset values, read-back of both registers, writes to unmapped addresses and the exact pull-up levels in the hold and run modes all depend on the register contents. Only the bench's scenarios, compared against its own model, can show these.

// File: rtl/odport_pkg.sv
package odport_pkg;
  typedef struct packed {
    logic wrData;
    logic wrPull;
    logic rdData;
    logic rdPull;
  } regStb_t;

  typedef enum logic [1:0] {
    PAD_RESET = 2'd0,
    PAD_RUN   = 2'd1,
    PAD_HOLD  = 2'd2,
    PAD_FLOAT = 2'd3
  } padMode_t;
endpackage

// File: rtl/odport_ctrl.sv
module odport_ctrl
  import odport_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 'h0F,
  parameter logic [AW-1:0] PULL_ADDR = 'h10
) (
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic          stopMode,
  input  logic          holdPins,
  output regStb_t       stb,
  output padMode_t      mode
);
  logic hitData;
  logic hitPull;

  assign hitData = (busAddr == DATA_ADDR);
  assign hitPull = (busAddr == PULL_ADDR);

  always_comb begin
    stb.wrData = busWe && hitData;
    stb.wrPull = busWe && hitPull;
    stb.rdData = busRe && hitData;
    stb.rdPull = busRe && hitPull;
  end

  // reset outranks stop mode
  always_comb begin
    if (!rstN)          mode = PAD_RESET;
    else if (!stopMode) mode = PAD_RUN;
    else if (holdPins)  mode = PAD_HOLD;
    else                mode = PAD_FLOAT;
  end
endmodule

// File: rtl/odport_dp.sv
module odport_dp
  import odport_pkg::*;
#(
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStb_t       stb,
  input  padMode_t      mode,
  input  logic [PW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [PW-1:0] drvLowEn,
  output logic [PW-1:0] pullUpEn
);
  logic [PW-1:0] dataQ;
  logic [PW-1:0] pullQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '1;
      pullQ <= '0;
    end else begin
      if (stb.wrData) dataQ <= wdata;
      if (stb.wrPull) pullQ <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (stb.rdData)      rdata[PW-1:0] = dataQ;
    else if (stb.rdPull) rdata[PW-1:0] = pullQ;
  end

  for (genvar i = 0; i < PW; i++) begin : g_pad
    always_comb begin
      drvLowEn[i] = 1'b0;
      pullUpEn[i] = 1'b0;
      unique case (mode)
        PAD_RUN: begin
          drvLowEn[i] = ~dataQ[i];
          pullUpEn[i] = pullQ[i] & dataQ[i];
        end
        PAD_HOLD: begin
          drvLowEn[i] = ~dataQ[i] & ~pullQ[i];
          pullUpEn[i] = pullQ[i];
        end
        default: begin
          drvLowEn[i] = 1'b0;
          pullUpEn[i] = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/odport_top.sv
module odport_top
  import odport_pkg::*;
#(
  parameter int PW = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 'h0F,
  parameter logic [AW-1:0] PULL_ADDR = 'h10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic          busWe,
  input  logic          busRe,
  output logic [DW-1:0] busRdata,
  input  logic          stopMode,
  input  logic          holdPins,
  output logic [PW-1:0] drvLowEn,
  output logic [PW-1:0] pullUpEn
);
  regStb_t  stb;
  padMode_t mode;
  logic     unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DW-1:PW];

  odport_ctrl #(.AW(AW), .DATA_ADDR(DATA_ADDR), .PULL_ADDR(PULL_ADDR)) u_ctrl (
    .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .stopMode(stopMode), .holdPins(holdPins), .stb(stb), .mode(mode)
  );

  odport_dp #(.PW(PW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode),
    .wdata(busWdata[PW-1:0]), .rdata(busRdata),
    .drvLowEn(drvLowEn), .pullUpEn(pullUpEn)
  );
endmodule

// File: rtl/odport_chk.sv
module odport_chk #(
  parameter int PW = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 'h0F
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic          busWe,
  input logic          busRe,
  input logic [DW-1:0] busRdata,
  input logic          stopMode,
  input logic          holdPins,
  input logic [PW-1:0] drvLowEn,
  input logic [PW-1:0] pullUpEn
);
  AST_RESET_RELEASES: assert property (@(posedge clk) !rstN |-> (pullUpEn == '0 && drvLowEn == '0)); // R9
  AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DATA_ADDR) ##1 !stopMode |-> drvLowEn == ~$past(busWdata[PW-1:0])); // R2
  AST_HOLD_NO_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && holdPins) |-> (drvLowEn & pullUpEn) == '0); // R7
  AST_STOP_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !holdPins) |-> (drvLowEn == '0 && pullUpEn == '0)); // R8
  AST_RUN_NO_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !stopMode |-> (drvLowEn & pullUpEn) == '0); // R10
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DW-1:PW] == '0); // R4
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == '0); // R6
endmodule

bind odport_top odport_chk #(.PW(PW), .DW(DW), .AW(AW), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
  .busRe(busRe), .busRdata(busRdata), .stopMode(stopMode), .holdPins(holdPins),
  .drvLowEn(drvLowEn), .pullUpEn(pullUpEn)
);

// File: tb/odport_top_tb.sv
`timescale 1ns/1ps
module odport_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic       busRe = 1'b0;
  logic [7:0] busRdata;
  logic       stopMode = 1'b0;
  logic       holdPins = 1'b0;
  logic [3:0] drvLowEn;
  logic [3:0] pullUpEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] mData = 4'hF;
  logic [3:0] mPull = 4'h0;

  always #10 clk = ~clk;

  odport_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .busRdata(busRdata), .stopMode(stopMode), .holdPins(holdPins),
    .drvLowEn(drvLowEn), .pullUpEn(pullUpEn)
  );

  function automatic logic [3:0] expDrv(input logic rst, input logic stp, input logic hld);
    if (!rst) return 4'h0;
    if (!stp) return ~mData;
    if (hld)  return ~mData & ~mPull;
    return 4'h0;
  endfunction

  function automatic logic [3:0] expPu(input logic rst, input logic stp, input logic hld);
    if (!rst) return 4'h0;
    if (!stp) return mPull & mData;
    if (hld)  return mPull;
    return 4'h0;
  endfunction

  function automatic logic [7:0] expRd(input logic [7:0] a, input logic re);
    if (!re) return 8'h00;
    if (a == 8'h0F) return {4'h0, mData};
    if (a == 8'h10) return {4'h0, mPull};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check before the edge, update model at the edge
  task automatic step(input logic rst, input logic [7:0] a, input logic [7:0] wd,
                      input logic we, input logic re, input logic stp, input logic hld,
                      input string tag);
    string tPad, tRd;
    @(negedge clk);
    rstN = rst; busAddr = a; busWdata = wd; busWe = we; busRe = re;
    stopMode = stp; holdPins = hld;
    #2;
    tPad = tag; tRd = tag;
    if (tag == "") begin
      if (!rst) tPad = "R9";
      else if (!stp) tPad = "R10";
      else if (hld) tPad = "R7";
      else tPad = "R8";
      if (!re) tRd = "R6";
      else if (a == 8'h0F) tRd = "R4";
      else if (a == 8'h10) tRd = "R5";
      else tRd = "R6";
    end
    chk(tRd, "busRdata", busRdata, expRd(a, re));
    chk(tPad, "drvLowEn", {4'h0, drvLowEn}, {4'h0, expDrv(rst, stp, hld)});
    chk(tPad, "pullUpEn", {4'h0, pullUpEn}, {4'h0, expPu(rst, stp, hld)});
    @(posedge clk);
    if (!rst) begin
      mData = 4'hF; mPull = 4'h0;
    end else if (we) begin
      if (a == 8'h0F) mData = wd[3:0];
      if (a == 8'h10) mPull = wd[3:0];
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R1 reset values read back
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    // R2 drive all low, then R3 release half
    step(1'b1, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 8'h0F, 8'h0A, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    // R4 upper bits ignored
    step(1'b1, 8'h0F, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    // R5 pull register, R10 pull only on released pins
    step(1'b1, 8'h10, 8'hF6, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    // R6 unmapped writes and reads, idle read
    step(1'b1, 8'h11, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h0E, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // R7 stop with hold, latch 0 with pull set
    step(1'b1, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
    // R8 stop without hold, contents kept
    step(1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    // R9 reset released while pull register is nonzero
    step(1'b1, 8'h0F, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    step(1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R1");

    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 8'h0F : (sel < 8) ? 8'h10 : 8'($urandom);
      step(($urandom_range(0, 39) != 0), a, 8'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0), 1'($urandom), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule